// File: doc/BRIEF.md
# Strobed Serial Display Port

This block is the slave end of a three-wire serial link that loads a segment display controller. A host pulls an active-low strobe down, clocks bits in on a shift clock, and releases the strobe to have the transfer acted on. The first byte of every transfer is a command. Its top bit selects one of two kinds. A setup command carries duty, frame rate, drive source, master/slave and test fields. A status command carries a row address, a display control code and a direction bit.

In write direction, the 56 bits that follow the command form one display row. That row is stored into one of four row latches, chosen by the row address of the same command. In read direction, the block shifts a 32-bit key word out on the shared data line. It can only pull the line low; a pull-up gives the high level. Shift clock, strobe and data are synchronised into the system clock. All work is done on edges detected in that domain.

Top module: `lcdp_port`

## Requirements
- R1: After reset all setup fields, the row address, display control, direction bit and all four rows are zero, and the data line is released (`sdata_pull_low` = 0).
- R2: Input bits are taken on rising shift-clock edges, most significant bit first, while the strobe is low. The first 8 bits form the command. The next bits fill a row whose first-received bit lands in row bit 55.
- R3: A command takes effect only when the strobe rises. While the strobe is low no setup, status or row output changes. A transfer that ends with fewer than 8 bits changes nothing.
- R4: A status command with bit 7 = 1 and bit 0 = 0 is a write. It stores the row into `rows_o[addr*56 +: 56]`, where addr = command bits 4:3. The row is stored only if at least 56 data bits arrived, and bits after the 56th are ignored. A shorter row is dropped, but the status fields are still applied.
- R5: The status command loads the row address from bits 4:3 and the direction from bit 0. Display control (bits 2:1) is loaded only for codes 00 (off) and 10 (normal). Codes 01 and 11 leave it unchanged.
- R6: A setup command has bit 7 = 0. Its fields sit at bits 1:0 (duty), 3:2 (frame), 4 (external drive), 5 (slave) and 6 (test). If bits 6:0 differ from the stored setup, they are stored and display control is forced to 00. If they are equal, nothing changes.
- R7: A status command with bit 0 = 1 makes the block shift out the key word, most significant bit first, during the same transfer. A new bit appears after each falling shift-clock edge that follows the command byte. A 0 bit pulls the line low. After 32 bits the line stays released, and the direction output shows 1 once the strobe rises.
- R8: While the strobe is high, the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stb_n | input | 1 | Active-low transfer strobe |
| sck | input | 1 | Shift clock, idles high |
| sdata_in | input | 1 | Sensed level of the shared data line |
| key_word | input | 32 | Key word to shift out in read direction |
| sdata_pull_low | output | 1 | Pulls the data line low when 1 |
| rows_o | output | 224 | Four 56-bit display rows, row 0 in the low bits |
| duty_o | output | 2 | Stored duty field |
| frame_o | output | 2 | Stored frame-rate field |
| ext_drive_o | output | 1 | Stored drive-source field |
| slave_o | output | 1 | Stored master/slave field |
| test_o | output | 1 | Stored test field |
| row_addr_o | output | 2 | Stored row address |
| disp_ctl_o | output | 2 | Stored display control (00 off, 10 normal) |
| key_read_o | output | 1 | Stored direction, 1 = key readout |

## Verification
The bench first repeats a setup command identical to the stored one while the display is on. A design that blanked the display anyway would fail there. It also sends status commands with codes 01 and 11, which must not disturb display control. It ends transfers after only part of a command, or with fewer or more than 56 data bits. This catches designs that latch a partial row, apply a half-received command, or let late bits shift the row. Key readout is compared bit by bit, including the release after the last bit, which exposes off-by-one shifts and a line left pulled low.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;

    localparam int CMD_W      = 8;
    localparam int TYPE_BIT   = 7;
    localparam int ADDR_LSB   = 3;
    localparam int CTL_LSB    = 1;
    localparam int DIR_BIT    = 0;
    localparam int ADDR_W     = 2;
    localparam int ROWS       = 1 << ADDR_W;

    typedef struct packed {
        logic       test;
        logic       slave;
        logic       ext_drive;
        logic [1:0] frame;
        logic [1:0] duty;
    } setup_t;

    localparam int SETUP_W = $bits(setup_t);

    typedef struct packed {
        logic [ADDR_W-1:0] row_addr;
        logic [1:0]        disp_ctl;
        logic              key_read;
    } status_t;

endpackage

// File: rtl/lcdp_sync.sv
module lcdp_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    localparam int CHAIN_W = STAGES * W;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
        logic [W-1:0]       prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic [CHAIN_W-1:0] shifted;

    generate
        if (STAGES > 1) begin : g_multi
            assign shifted = {st_q.chain[CHAIN_W-W-1:0], din};
        end else begin : g_single
            assign shifted = din;
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.chain = shifted;
        st_d.prev  = st_q.chain[CHAIN_W-1 -: W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RST_VAL}};
            st_q.prev  <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[CHAIN_W-1 -: W];
    assign rise = dout & ~st_q.prev;
    assign fall = ~dout & st_q.prev;
endmodule

// File: rtl/lcdp_rx.sv
module lcdp_rx #(
    parameter int CMD_W = 8,
    parameter int ROW_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_low,
    input  logic             stb_fall,
    input  logic             sck_rise,
    input  logic             din,
    output logic [CMD_W-1:0] cmd_o,
    output logic [ROW_W-1:0] row_o,
    output logic             cmd_full_o,
    output logic             row_full_o,
    output logic             cmd_done_o
);
    localparam int TOTAL = CMD_W + ROW_W;
    localparam int CNT_W = $clog2(TOTAL + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CMD_W-1:0] cmd;
        logic [ROW_W-1:0] row;
        logic             done;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (stb_fall) begin
            st_d.cnt = '0;
            st_d.cmd = '0;
            st_d.row = '0;
        end else if (stb_low && sck_rise && st_q.cnt < CNT_W'(TOTAL)) begin
            if (st_q.cnt < CNT_W'(CMD_W)) begin
                st_d.cmd  = {st_q.cmd[CMD_W-2:0], din};
                st_d.done = (st_q.cnt == CNT_W'(CMD_W - 1));
            end else begin
                st_d.row = {st_q.row[ROW_W-2:0], din};
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_o      = st_q.cmd;
    assign row_o      = st_q.row;
    assign cmd_full_o = (st_q.cnt >= CNT_W'(CMD_W));
    assign row_full_o = (st_q.cnt == CNT_W'(TOTAL));
    assign cmd_done_o = st_q.done;
endmodule

// File: rtl/lcdp_tx.sv
module lcdp_tx #(
    parameter int KEY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             load,
    input  logic [KEY_W-1:0] key_word,
    input  logic             sck_fall,
    output logic             pull_low
);
    typedef struct packed {
        logic [KEY_W-1:0] sh;
        logic             active;
        logic             low;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop) begin
            st_d.active = 1'b0;
            st_d.low    = 1'b0;
        end else if (load) begin
            st_d.sh     = key_word;
            st_d.active = 1'b1;
            st_d.low    = 1'b0;
        end else if (st_q.active && sck_fall) begin
            st_d.low = ~st_q.sh[KEY_W-1];
            st_d.sh  = {st_q.sh[KEY_W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pull_low = st_q.low;
endmodule

// File: rtl/lcdp_regs.sv
module lcdp_regs
    import lcdp_pkg::*;
#(
    parameter int ROW_W = 56
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [CMD_W-1:0]           cmd,
    input  logic                       cmd_full,
    input  logic [ROW_W-1:0]           row,
    input  logic                       row_full,
    output setup_t                     setup_o,
    output status_t                    status_o,
    output logic [ROWS-1:0][ROW_W-1:0] rows_o
);
    typedef struct packed {
        setup_t                     setup;
        status_t                    status;
        logic [ROWS-1:0][ROW_W-1:0] rows;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        ctl;

    assign addr = cmd[ADDR_LSB +: ADDR_W];
    assign ctl  = cmd[CTL_LSB +: 2];

    always_comb begin
        st_d = st_q;
        if (commit && cmd_full) begin
            if (!cmd[TYPE_BIT]) begin
                if (cmd[SETUP_W-1:0] != st_q.setup) begin
                    st_d.setup           = setup_t'(cmd[SETUP_W-1:0]);
                    st_d.status.disp_ctl = 2'b00;
                end
            end else begin
                st_d.status.row_addr = addr;
                st_d.status.key_read = cmd[DIR_BIT];
                if (!ctl[0]) st_d.status.disp_ctl = ctl;
                if (!cmd[DIR_BIT] && row_full) st_d.rows[addr] = row;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign setup_o  = st_q.setup;
    assign status_o = st_q.status;
    assign rows_o   = st_q.rows;
endmodule

// File: rtl/lcdp_port.sv
module lcdp_port
    import lcdp_pkg::*;
#(
    parameter int ROW_W       = 56,
    parameter int KEY_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stb_n,
    input  logic                  sck,
    input  logic                  sdata_in,
    input  logic [KEY_W-1:0]      key_word,
    output logic                  sdata_pull_low,
    output logic [ROWS*ROW_W-1:0] rows_o,
    output logic [1:0]            duty_o,
    output logic [1:0]            frame_o,
    output logic                  ext_drive_o,
    output logic                  slave_o,
    output logic                  test_o,
    output logic [ADDR_W-1:0]     row_addr_o,
    output logic [1:0]            disp_ctl_o,
    output logic                  key_read_o
);
    localparam int IDX_STB = 2;
    localparam int IDX_SCK = 1;
    localparam int IDX_DAT = 0;

    logic [2:0] s_val, s_rise, s_fall;
    logic       stb_s;
    logic [CMD_W-1:0] cmd;
    logic [ROW_W-1:0] row;
    logic       cmd_full, row_full, cmd_done, key_load;
    setup_t     setup;
    status_t    status;
    logic [ROWS-1:0][ROW_W-1:0] rows;

    lcdp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({stb_n, sck, sdata_in}),
        .dout(s_val), .rise(s_rise), .fall(s_fall)
    );

    assign stb_s = s_val[IDX_STB];

    lcdp_rx #(.CMD_W(CMD_W), .ROW_W(ROW_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .stb_low(!stb_s), .stb_fall(s_fall[IDX_STB]),
        .sck_rise(s_rise[IDX_SCK]), .din(s_val[IDX_DAT]),
        .cmd_o(cmd), .row_o(row), .cmd_full_o(cmd_full),
        .row_full_o(row_full), .cmd_done_o(cmd_done)
    );

    assign key_load = cmd_done && cmd[TYPE_BIT] && cmd[DIR_BIT];

    lcdp_tx #(.KEY_W(KEY_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .stop(s_rise[IDX_STB] || s_fall[IDX_STB]),
        .load(key_load), .key_word(key_word),
        .sck_fall(s_fall[IDX_SCK]), .pull_low(sdata_pull_low)
    );

    lcdp_regs #(.ROW_W(ROW_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(s_rise[IDX_STB]),
        .cmd(cmd), .cmd_full(cmd_full), .row(row), .row_full(row_full),
        .setup_o(setup), .status_o(status), .rows_o(rows)
    );

    assign rows_o      = rows;
    assign duty_o      = setup.duty;
    assign frame_o     = setup.frame;
    assign ext_drive_o = setup.ext_drive;
    assign slave_o     = setup.slave;
    assign test_o      = setup.test;
    assign row_addr_o  = status.row_addr;
    assign disp_ctl_o  = status.disp_ctl;
    assign key_read_o  = status.key_read;
endmodule

// File: rtl/lcdp_port_chk.sv
module lcdp_port_chk #(
    parameter int SETUP_W = 7,
    parameter int ROWS_W  = 224
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stb_high,
    input logic               pull_low,
    input logic [SETUP_W-1:0] setup_vec,
    input logic [1:0]         disp_ctl,
    input logic [1:0]         row_addr,
    input logic               key_read,
    input logic [ROWS_W-1:0]  rows
);
    // R8: strobe high releases the data line by the next cycle
    a_r8_line_released: assert property (@(posedge clk) disable iff (!rst_n)
        stb_high |=> !pull_low);

    // R5: only codes 00 and 10 are ever held
    a_r5_ctl_legal: assert property (@(posedge clk) disable iff (!rst_n)
        disp_ctl[0] == 1'b0);

    // R3: nothing stored moves while the strobe is low
    a_r3_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_high |=> ($stable(setup_vec) && $stable(disp_ctl)
                       && $stable(row_addr) && $stable(key_read) && $stable(rows)));

    // R6: a new setup always comes with display control 00
    a_r6_setup_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_vec != $past(setup_vec)) |-> (disp_ctl == 2'b00));

    // R4: rows change only on the cycle after a strobe rise
    a_r4_rows_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (rows != $past(rows)) |-> $past(stb_high));
endmodule

bind lcdp_port lcdp_port_chk #(.SETUP_W(lcdp_pkg::SETUP_W), .ROWS_W(lcdp_pkg::ROWS * ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stb_high(stb_s), .pull_low(sdata_pull_low),
    .setup_vec(setup), .disp_ctl(disp_ctl_o), .row_addr(row_addr_o),
    .key_read(key_read_o), .rows(rows_o)
);

// File: tb/lcdp_port_tb_top.sv
module lcdp_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb_n = 1'b1;
    logic sck = 1'b1;
    logic sdi = 1'b1;
    logic [31:0] key_word = '0;
    logic pull_low;
    logic [223:0] rows_o;
    logic [1:0] duty_o, frame_o, row_addr_o, disp_ctl_o;
    logic ext_drive_o, slave_o, test_o, key_read_o;

    int total = 0;
    int bad = 0;

    logic [6:0]  m_setup = '0;
    logic [1:0]  m_addr  = '0;
    logic [1:0]  m_ctl   = '0;
    logic        m_rd    = 1'b0;
    logic [55:0] m_rows [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdp_port dut_i (
        .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .sck(sck), .sdata_in(sdi),
        .key_word(key_word), .sdata_pull_low(pull_low), .rows_o(rows_o),
        .duty_o(duty_o), .frame_o(frame_o), .ext_drive_o(ext_drive_o),
        .slave_o(slave_o), .test_o(test_o), .row_addr_o(row_addr_o),
        .disp_ctl_o(disp_ctl_o), .key_read_o(key_read_o)
    );

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [223:0] exp_rows();
        return {m_rows[3], m_rows[2], m_rows[1], m_rows[0]};
    endfunction

    task automatic check_all(input string ctx);
        chk({ctx, " R6 setup"}, 256'({test_o, slave_o, ext_drive_o, frame_o, duty_o}), 256'(m_setup));
        chk({ctx, " R5 status"}, 256'({row_addr_o, disp_ctl_o, key_read_o}), 256'({m_addr, m_ctl, m_rd}));
        chk({ctx, " R4 rows"}, 256'(rows_o), 256'(exp_rows()));
    endtask

    function automatic void model_apply(input logic [7:0] cmd, input int nbits, input logic [63:0] pay);
        if (!cmd[7]) begin
            if (cmd[6:0] != m_setup) begin
                m_setup = cmd[6:0];
                m_ctl   = 2'b00;
            end
        end else begin
            m_addr = cmd[4:3];
            m_rd   = cmd[0];
            if (!cmd[1]) m_ctl = cmd[2:1];
            if (!cmd[0] && nbits >= 56) m_rows[cmd[4:3]] = pay[63 -: 56];
        end
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sck_bit(input logic b);
        sck = 1'b0;
        sdi = b;
        wait_clk(HALF);
        sck = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic frame_write(input logic [7:0] cmd, input int nbits, input logic [63:0] pay);
        stb_n = 1'b0;
        wait_clk(HALF);
        for (int i = 7; i >= 0; i--) sck_bit(cmd[i]);
        for (int i = 0; i < nbits; i++) sck_bit(pay[63-i]);
        wait_clk(HALF);
        // R3: nothing applied before the strobe rises
        chk("R3 hold while low", 256'({row_addr_o, disp_ctl_o, key_read_o, rows_o}),
            256'({m_addr, m_ctl, m_rd, exp_rows()}));
        stb_n = 1'b1;
        wait_clk(10);
        model_apply(cmd, nbits, pay);
        sdi = 1'b1;
    endtask

    task automatic frame_read(input logic [7:0] cmd, input logic [31:0] key);
        logic [31:0] got;
        key_word = key;
        stb_n = 1'b0;
        wait_clk(HALF);
        for (int i = 7; i >= 0; i--) sck_bit(cmd[i]);
        sdi = 1'b1;
        wait_clk(12);
        for (int i = 31; i >= 0; i--) begin
            sck = 1'b0;
            wait_clk(HALF);
            got[i] = ~pull_low;
            sck = 1'b1;
            wait_clk(HALF);
        end
        chk("R7 key word", 256'(got), 256'(key));
        sck = 1'b0;
        wait_clk(HALF);
        chk("R7 released after last bit", 256'(pull_low), 256'(0));
        sck = 1'b1;
        wait_clk(HALF);
        stb_n = 1'b1;
        wait_clk(10);
        model_apply(cmd, 0, '0);
        chk("R8 released with strobe high", 256'(pull_low), 256'(0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] pay;
        for (int r = 0; r < 4; r++) m_rows[r] = '0;
        void'($urandom(32'h5eed_1234));
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R1 reset state
        check_all("R1 reset");
        chk("R1 line released", 256'(pull_low), 256'(0));

        // R2 bit order: first data bit into row bit 55 of row 2
        pay = 64'hA5C3_0F1E_2D3C_4B00;
        frame_write(8'b1001_0100, 56, pay);
        chk("R2 first bit at row bit 55", 256'(rows_o[2*56+55]), 256'(1'b1));
        chk("R2 row image", 256'(rows_o[2*56 +: 56]), 256'(pay[63 -: 56]));
        check_all("R2");

        // R3 partial command: 5 bits then strobe high
        stb_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 5; i++) sck_bit(1'b0);
        wait_clk(HALF);
        stb_n = 1'b1;
        wait_clk(10);
        check_all("R3 partial command");

        // R4 short row is dropped, status still applied
        frame_write(8'b1000_1100, 20, 64'hFFFF_FFFF_FFFF_FFFF);
        check_all("R4 short row");

        // R4 extra bits past 56 ignored
        frame_write(8'b1001_1100, 60, 64'h1234_5678_9ABC_DEF0);
        check_all("R4 extra bits");

        // R5 codes 01 and 11 leave display control unchanged
        frame_write(8'b1000_0010, 0, '0);
        check_all("R5 code 01");
        frame_write(8'b1110_0110, 0, '0);
        check_all("R5 code 11");

        // R6 identical setup keeps display on
        chk("R6 precondition display on", 256'(disp_ctl_o), 256'(2'b10));
        frame_write(8'b0000_0000, 0, '0);
        check_all("R6 same setup");
        chk("R6 display stays on", 256'(disp_ctl_o), 256'(2'b10));
        // R6 new setup blanks display
        frame_write(8'b0101_1001, 0, '0);
        check_all("R6 new setup");
        chk("R6 display forced off", 256'(disp_ctl_o), 256'(2'b00));

        // R7 key readout
        frame_read(8'b1000_0101, 32'h8C3A_F015);
        check_all("R7 after read");

        // R8 idle
        wait_clk(20);
        chk("R8 idle released", 256'(pull_low), 256'(0));

        // random traffic
        for (int n = 0; n < 45; n++) begin
            int kind;
            logic [7:0] cmd;
            int nb;
            kind = int'($urandom % 4);
            cmd  = 8'($urandom);
            pay  = {$urandom, $urandom};
            if (kind == 0) begin
                cmd[7] = 1'b0;
                frame_write(cmd, 0, '0);
            end else if (kind == 3) begin
                cmd[7] = 1'b1;
                cmd[0] = 1'b1;
                frame_read(cmd, $urandom);
            end else begin
                cmd[7] = 1'b1;
                cmd[0] = 1'b0;
                nb = (kind == 1) ? 56 : int'($urandom % 64);
                frame_write(cmd, nb, pay);
            end
            check_all("random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule